// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a serial management master that talks to an Ethernet PHY over the two-wire MDC/MDIO management interface. Software controls it through a small register port. One write to the frame register launches one transaction, either a read or a write. The block first sends a preamble of ones. It then shifts the 32-bit frame out MSB first on MDIO while it generates MDC from the system clock.

On a read, the block lets go of MDIO from the turnaround bits onward and collects sixteen bits from the PHY. It then writes those bits into the low half of the frame register, so software reads the result where it wrote the command. When any transaction ends, a completion event bit is set. That bit can be polled, or it can be routed to an interrupt through a mask bit. The MDC half-period is set by a speed register in system clocks. Software normally programs that register to the clock frequency in MHz divided by 5, plus 1, which keeps MDC at or below 2.5 MHz.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A transaction sends PRE_LEN (default 32) ones on MDIO, then the 32 frame bits MSB first. The frame register fields are: [31:30] start, [29:28] opcode (2'b10 is a read, any other value is a write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, and [15:0] data.
- R2: When the speed register (address 3) holds S>0, MDC stays high for S system clocks and low for S system clocks, and it is low when the block is idle. MDIO output changes only on the clock edge where MDC falls, and a transaction lasts exactly 2*S*(PRE_LEN+32) clocks, counted from the edge where the frame write is taken.
- R3: On a write-opcode frame, mdio_oe is high for all PRE_LEN+32 bit periods.
- R4: On a read-opcode frame, mdio_oe goes low from the first turnaround bit to the end of the frame. The PHY's sixteen data bits are sampled on MDC rising edges, MSB first. They replace frame register bits [15:0], and bits [31:16] keep their values.
- R5: At the end of a transaction, bit 0 of the event register (address 1) is set in the same cycle that busy falls. This happens whatever the mask bit holds.
- R6: Writing 1 to event bit 0 clears it, and writing 0 leaves it unchanged. If a clear write falls in the same cycle as a completion, the bit ends up set.
- R7: irq equals event bit 0 AND mask bit 0 (mask register, address 2). It follows a mask write or an event write in the cycle that write is taken.
- R8: While the speed register is 0, MDC stays low. A frame write in that state starts nothing and does not change the frame register.
- R9: busy goes high in the cycle after an accepted frame write (frame register, address 0) and stays high until completion. A frame write while busy is dropped: the frame register and the transaction are unaffected.
- R10: rd_data returns the register selected by rd_addr one clock later. After reset every register reads 0, and busy, irq, mdc and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Transaction in progress |
| irq | output | 1 | Masked completion interrupt |

## Verification
Two functions can land on the same clock edge: the hardware setting the completion bit when a frame ends, and a software write-one-to-clear aimed at that bit. The bench counts 2*S*(PRE_LEN+32) clocks from the frame write so that its clear write is taken on exactly the completion edge. It then reads the event register back and expects the bit to be set. Writes of 0 and a later clear confirm the other two outcomes. A frame write while busy, which would otherwise collide with the running transfer, is judged by reading the frame register back after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] ADDR_FRAME = 2'd0;
  localparam logic [1:0] ADDR_EVENT = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;
  localparam logic [1:0] ADDR_SPEED = 2'd3;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam int         FRAME_W    = 32;
  localparam int         DATA_W     = 16;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] speed,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt;
  logic             tick;

  assign tick = run && (speed != '0) && (cnt >= speed - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run || speed == '0) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_mdc_off: assert property (@(posedge clk) disable iff (rst)
    (speed == '0) |=> !mdc);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               active,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rdata,
  output logic               done
);
  localparam int TOTAL   = PRE_LEN + FRAME_W;
  localparam int IDX_W   = $clog2(TOTAL + 1);
  localparam int TA_POS  = PRE_LEN + 14;
  localparam int DAT_POS = PRE_LEN + 16;

  logic [FRAME_W-1:0] frame_q;
  logic               rd_mode;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   nxt;

  assign nxt  = idx + 1'b1;
  assign done = active && fall && (int'(idx) == TOTAL - 1);

  function automatic logic stream_bit(input logic [IDX_W-1:0] k,
                                      input logic [FRAME_W-1:0] f);
    int pos;
    if (int'(k) < PRE_LEN) return 1'b1;
    pos = FRAME_W - 1 - (int'(k) - PRE_LEN);
    return f[pos[4:0]];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      frame_q <= '0;
      rd_mode <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      idx     <= '0;
      frame_q <= frame_in;
      rd_mode <= (frame_in[29:28] == OP_READ);
      mdio_o  <= (PRE_LEN > 0) ? 1'b1 : frame_in[FRAME_W-1];
      mdio_oe <= 1'b1;
      rdata   <= '0;
    end else if (active) begin
      if (rise && rd_mode && int'(idx) >= DAT_POS)
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (int'(idx) == TOTAL - 1) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          idx     <= nxt;
          mdio_o  <= stream_bit(nxt, frame_q);
          mdio_oe <= !(rd_mode && int'(nxt) >= TA_POS);
        end
      end
    end
  end

  // R2: MDIO moves only together with a falling MDC
  a_r2_mdio_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && active && (mdio_o != $past(mdio_o))) |-> $past(fall));
  a_r3_write_driven: assert property (@(posedge clk) disable iff (rst)
    (active && !rd_mode) |-> mdio_oe);
  a_r4_ta_released: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode && int'(idx) >= TA_POS) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int SPD_W   = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        irq
);
  logic [FRAME_W-1:0] frame_q;
  logic [SPD_W-1:0]   speed_q;
  logic               mask_q;
  logic               ev_done;
  logic               ev_next;
  logic               mask_next;
  logic               seq_done;
  logic               seq_active;
  logic               rise_p;
  logic               fall_p;
  logic [DATA_W-1:0]  seq_rdata;
  logic               wr_frame;
  logic               start;

  assign wr_frame = wr_en && (wr_addr == ADDR_FRAME);
  assign start    = wr_frame && !seq_active && (speed_q != '0);
  assign busy     = seq_active;

  mdio_mdc_gen #(.SPD_W(SPD_W)) mdc_gen_i (
    .clk   (clk),
    .rst   (rst),
    .run   (seq_active),
    .speed (speed_q),
    .mdc   (mdc),
    .rise  (rise_p),
    .fall  (fall_p)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frame_in (wr_data),
    .rise     (rise_p),
    .fall     (fall_p),
    .mdio_i   (mdio_i),
    .active   (seq_active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (seq_rdata),
    .done     (seq_done)
  );

  always_comb begin
    ev_next = ev_done;
    if (wr_en && wr_addr == ADDR_EVENT && wr_data[0]) ev_next = 1'b0;
    if (seq_done) ev_next = 1'b1;
    mask_next = mask_q;
    if (wr_en && wr_addr == ADDR_MASK) mask_next = wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      speed_q <= '0;
      mask_q  <= 1'b0;
      ev_done <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      ev_done <= ev_next;
      mask_q  <= mask_next;
      irq     <= ev_next && mask_next;
      if (wr_en && wr_addr == ADDR_SPEED) speed_q <= wr_data[SPD_W-1:0];
      if (start)
        frame_q <= wr_data;
      else if (seq_done && frame_q[29:28] == OP_READ)
        frame_q[DATA_W-1:0] <= seq_rdata;
      unique case (rd_addr)
        ADDR_FRAME: rd_data <= frame_q;
        ADDR_EVENT: rd_data <= {31'd0, ev_done};
        ADDR_MASK:  rd_data <= {31'd0, mask_q};
        default:    rd_data <= {{(32-SPD_W){1'b0}}, speed_q};
      endcase
    end
  end

  a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_frame && !seq_done) |=> $stable(frame_q));
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ev_done);
  a_r8_no_start_when_off: assert property (@(posedge clk) disable iff (rst)
    (wr_frame && !busy && speed_q == '0) |=> !busy);
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
  localparam int NBITS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_i, mdio_o, mdio_oe, busy, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .irq(irq)
  );

  // frame, PHY return data, speed
  localparam logic [31:0] V_FRAME [4] = '{32'h50821234, 32'h618A0000, 32'h6FFE5555, 32'h507E8001};
  localparam logic [15:0] V_RET   [4] = '{16'h0000, 16'hBEEF, 16'h0A0F, 16'h0000};
  localparam int          V_SPD   [4] = '{2, 1, 3, 4};

  // bus monitor and PHY model, sampled away from the active edge
  int          rises, falls, hi_cnt, hi_min, hi_max, mdio_bad;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_word;
  logic        mdc_prev = 1'b0, mo_prev = 1'b1;

  initial mdio_i = 1'b1;

  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      rises  = rises + 1;
      cap_o  = {cap_o[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
    end
    if (mdc) hi_cnt = hi_cnt + 1;
    if (!mdc && mdc_prev) begin
      falls = falls + 1;
      if (hi_cnt < hi_min) hi_min = hi_cnt;
      if (hi_cnt > hi_max) hi_max = hi_cnt;
      hi_cnt = 0;
      if (falls >= 48 && falls <= 63) mdio_i = phy_word[15 - (falls - 48)];
      else mdio_i = 1'b1;
    end
    if (mdio_o !== mo_prev && !(!mdc && mdc_prev)) mdio_bad = mdio_bad + 1;
    mdc_prev = mdc;
    mo_prev  = mdio_o;
  end

  task automatic clr_mon();
    rises = 0; falls = 0; hi_cnt = 0; hi_min = 1000; hi_max = 0; mdio_bad = 0;
    cap_o = '0; cap_oe = '0;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    clr_mon();
    phy_word = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: reset state
    @(negedge clk);
    check(!busy && !irq && !mdc && !mdio_oe, "R10 idle outputs", {busy, irq, mdc, mdio_oe}, 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], r);
      check(r == 0, "R10 reset register", r, 0);
    end

    // R8: speed 0 blocks a start and leaves frame untouched
    wr_reg(2'd0, 32'h50821234);
    repeat (10) begin
      @(negedge clk);
      check(!busy && !mdc, "R8 no start at speed 0", {busy, mdc}, 0);
    end
    rd_reg(2'd0, r);
    check(r == 0, "R8 frame unchanged", r, 0);

    // R1 R2 R3 R4 R5 R7: table of vectors
    for (int i = 0; i < 4; i++) begin
      automatic int s = V_SPD[i];
      automatic bit is_rd = (V_FRAME[i][29:28] == 2'b10);
      automatic logic [31:0] exp_f = is_rd ? {V_FRAME[i][31:16], V_RET[i]} : V_FRAME[i];
      automatic logic [63:0] exp_s = {32'hFFFFFFFF, V_FRAME[i]};
      automatic logic [63:0] exp_oe = is_rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
      wr_reg(2'd3, s);
      wr_reg(2'd2, i % 2);
      wr_reg(2'd1, 1);
      rd_reg(2'd3, r);
      check(r == s, "R10 speed readback", r, s);
      clr_mon();
      phy_word = V_RET[i];
      wr_reg(2'd0, V_FRAME[i]);
      repeat (2 * s * NBITS - 1) @(posedge clk);
      @(negedge clk);
      check(busy, "R2 busy before last edge", busy, 1);
      @(posedge clk);
      @(negedge clk);
      check(!busy, "R2 R5 busy falls at end", busy, 0);
      check(irq == (i % 2), "R7 irq follows mask", irq, i % 2);
      rd_reg(2'd1, r);
      check(r == 1, "R5 event set", r, 1);
      rd_reg(2'd0, r);
      check(r == exp_f, is_rd ? "R4 read data in frame" : "R1 frame kept", r, exp_f);
      check(rises == NBITS && falls == NBITS, "R2 MDC cycle count", {rises[31:0], falls[31:0]}, {32'd64, 32'd64});
      check(hi_min == s && hi_max == s, "R2 MDC half period", {hi_min[31:0], hi_max[31:0]}, {s[31:0], s[31:0]});
      check(mdio_bad == 0, "R2 MDIO changes on fall", mdio_bad, 0);
      if (is_rd)
        check(cap_o[63:18] == exp_s[63:18], "R1 R4 read header bits", cap_o, exp_s);
      else
        check(cap_o == exp_s, "R1 write stream", cap_o, exp_s);
      check(cap_oe == exp_oe, is_rd ? "R4 turnaround release" : "R3 write drive", cap_oe, exp_oe);
    end

    // R6: set wins over a same-cycle clear; W1C semantics
    wr_reg(2'd2, 0);
    wr_reg(2'd3, 1);
    wr_reg(2'd1, 1);
    clr_mon();
    wr_reg(2'd0, 32'h507E8001);
    repeat (2 * NBITS - 1) @(posedge clk);
    wr_reg(2'd1, 1);
    rd_reg(2'd1, r);
    check(r == 1, "R6 set beats same-cycle clear", r, 1);
    wr_reg(2'd1, 0);
    rd_reg(2'd1, r);
    check(r == 1, "R6 write 0 keeps event", r, 1);
    check(!irq, "R7 irq low with mask 0", irq, 0);
    wr_reg(2'd2, 1);
    @(negedge clk);
    check(irq, "R7 irq after mask set", irq, 1);
    wr_reg(2'd1, 1);
    rd_reg(2'd1, r);
    check(r == 0, "R6 write 1 clears", r, 0);
    check(!irq, "R7 irq after clear", irq, 0);

    // R9: frame write while busy is dropped
    wr_reg(2'd3, 2);
    wr_reg(2'd0, 32'h50821234);
    repeat (10) @(posedge clk);
    wr_reg(2'd0, 32'h6FFE0000);
    @(negedge clk);
    check(busy, "R9 busy held", busy, 1);
    while (busy) @(negedge clk);
    repeat (20) begin
      @(negedge clk);
      check(!busy, "R9 no second transaction", busy, 0);
    end
    rd_reg(2'd0, r);
    check(r == 32'h50821234, "R9 frame unchanged by busy write", r, 32'h50821234);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule